// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Dispatcher

This block sits between instruction fetch and two execution units, called the left unit and the right unit. It takes one 32-bit fetched word at a time. The two top bits of the word say how the word is issued. It holds either one long instruction with a 30-bit payload, or two 15-bit short instructions. A short pair runs in one of two sequential orders, or as a parallel pair.

The dispatcher splits the word into its slots and gives each slot a 6-bit opcode-group index. It then issues the slots one at a time as single-cycle strobes. After each slot it waits for a completion handshake. The completion carries three flags: branch taken, exception and condition result. These flags decide whether the other slot of the pair still runs.

A short slot whose group index falls in a configurable set is a condition-test type. In a parallel pair, such a slot gates its partner. Eight wrapping counters record how words and slots were dispatched.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, `busy` and `iss_valid` are 0 and all eight counters read 0.
- R2: Format code 11 in bits 31:30 issues one slot on the left unit (`iss_side`=0, left=0 and right=1) with `iss_long`=1. Its payload is word bits 29:0 and its group is word bits 29:24. `busy` falls once that slot completes, whatever the completion flags are.
- R3: A short slot's payload is the slot zero-extended to 30 bits, and its group is the slot's own bits 14:9. The left slot is word bits 29:15 and the right slot is word bits 14:0.
- R4: Format code 10 issues the right slot first and then the left slot. Format code 01 issues the left slot first and then the right slot. `iss_test` is 0 for both slots in these formats.
- R5: In a sequential format, a first completion with branch or exception set suppresses the second slot. The branch-skip counter counts only skips where branch is set and exception is clear.
- R6: In a parallel pair (code 00) whose left slot is condition-test type, the left slot issues first with `iss_test`=1. The right slot then issues only if that completion reports condition true. This bumps the condition-true counter, or the condition-false counter otherwise. With the default mask, group indices 0x3C to 0x3F are condition-test type.
- R7: In a parallel pair where only the right slot is condition-test type, the right slot issues first with `iss_test`=1. The left slot then follows under the rule of R6.
- R8: When both slots of a parallel pair are condition-test type, the left slot acts as the test.
- R9: In a parallel pair with no condition-test slot, the left slot issues and then the right slot, unless the left completion reports an exception. A branch flag has no effect here.
- R10: Every accepted word bumps the cycle counter. Each word also bumps exactly one of the long, parallel, left-then-right and right-then-left counters, chosen by its format.
- R11: A word is accepted when `word_valid` is 1 and `busy` is 0. After acceptance, `busy` and the first `iss_valid` appear in the next cycle. A further issue appears only in the cycle after a completion. A word presented while busy is ignored.
- R12: A completion pulse while idle changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Fetched word present |
| word_data | input | 32 | Fetched instruction word |
| busy | output | 1 | A word is in progress |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_side | output | 1 | Target unit: 0 left, 1 right |
| iss_long | output | 1 | Issued slot is a long instruction |
| iss_test | output | 1 | Issued slot gates its partner |
| iss_payload | output | 30 | Slot payload, short slots zero-extended |
| iss_group | output | 6 | Opcode-group index of the slot |
| done_valid | input | 1 | Completion of the issued slot |
| done_branch | input | 1 | Completed slot changed the PC |
| done_exc | input | 1 | Completed slot raised an exception |
| done_cond | input | 1 | Condition-test result |
| cnt_cycles | output | CNT_W | Words accepted |
| cnt_long | output | CNT_W | Long words |
| cnt_par | output | CNT_W | Parallel words |
| cnt_lr | output | CNT_W | Left-then-right words |
| cnt_rl | output | CNT_W | Right-then-left words |
| cnt_true | output | CNT_W | Condition tests that passed |
| cnt_false | output | CNT_W | Condition tests that failed |
| cnt_bskip | output | CNT_W | Sequential slots skipped by a taken branch |

## Verification
The bench targets the skip rules with each flag combination:
- A branch together with an exception must skip the second slot but leave the branch-skip counter alone. A design that counted every skip would overcount.
- A branch in a parallel pair must not skip. A design that reused the sequential rule would drop the right slot.
- A pair whose slots are both condition-test type must use the left slot as the test. A design that got the priority backwards would issue right first.
- A condition-test group in a sequential word must not be flagged as a test.

A word presented while busy, and a completion presented while idle, must leave the issue stream and the counters untouched. A design without these guards would issue stray slots.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
  localparam int WORD_W  = 32;
  localparam int SLOT_W  = 15;
  localparam int PAY_W   = 30;
  localparam int GRP_W   = 6;
  localparam int NGRP    = 2 ** GRP_W;
  localparam int NUM_CNT = 8;

  // counter slots
  localparam int CI_CYC   = 0;
  localparam int CI_LONG  = 1;
  localparam int CI_PAR   = 2;
  localparam int CI_LR    = 3;
  localparam int CI_RL    = 4;
  localparam int CI_TRUE  = 5;
  localparam int CI_FALSE = 6;
  localparam int CI_BSKIP = 7;

  localparam logic SIDE_L = 1'b0;
  localparam logic SIDE_R = 1'b1;

  // top-bit format codes (R2, R4, R6)
  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  // how the second slot is gated by the first completion
  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_SEQ    = 2'd1,
    MD_COND   = 2'd2,
    MD_PAR    = 2'd3
  } mode_e;

  typedef struct packed {
    logic             side;
    logic             lng;
    logic             test;
    logic [PAY_W-1:0] pay;
    logic [GRP_W-1:0] grp;
  } slot_t;

  typedef struct packed {
    fmt_e  fmt;
    slot_t lslot;
    slot_t rslot;
    slot_t wide;
  } dec_t;
endpackage

// File: rtl/pkt_slot_decode.sv
module pkt_slot_decode
  import pkt_dispatch_pkg::*;
#(
  parameter logic [NGRP-1:0] TEST_MASK = 64'hF000_0000_0000_0000
) (
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);

  // g_short[0] is the right slot (low bits), g_short[1] the left slot (R3)
  for (genvar i = 0; i < 2; i++) begin : g_short
    logic [SLOT_W-1:0] bits;
    slot_t             s;
    assign bits = word[i*SLOT_W +: SLOT_W];
    always_comb begin
      s      = '0;
      s.side = (i == 0) ? SIDE_R : SIDE_L;
      s.lng  = 1'b0;
      s.pay  = PAY_W'(bits);
      s.grp  = bits[SLOT_W-1 -: GRP_W];
      s.test = TEST_MASK[bits[SLOT_W-1 -: GRP_W]];
    end
  end

  always_comb begin
    dec.fmt       = fmt_e'(word[WORD_W-1 -: 2]);
    dec.rslot     = g_short[0].s;
    dec.lslot     = g_short[1].s;
    dec.wide      = '0;
    dec.wide.side = SIDE_L;                       // R2
    dec.wide.lng  = 1'b1;
    dec.wide.test = 1'b0;
    dec.wide.pay  = word[PAY_W-1:0];
    dec.wide.grp  = word[PAY_W-1 -: GRP_W];
  end

endmodule

// File: rtl/pkt_issue_fsm.sv
module pkt_issue_fsm
  import pkt_dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  dec_t               dec,
  input  logic               done_valid,
  input  logic               done_branch,
  input  logic               done_exc,
  input  logic               done_cond,
  output logic               busy,
  output logic               iss_valid,
  output slot_t              iss_slot,
  output logic [NUM_CNT-1:0] inc
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT1, ST_WAIT2} state_e;

  state_e state;
  mode_e  mode_q, mode_n;
  slot_t  second_q, first_n, second_n;
  logic   accept, done1, go_second;

  assign accept = word_valid && (state == ST_IDLE);   // R11
  assign done1  = done_valid && (state == ST_WAIT1);

  // plan the word: which slot first, which second, how gated
  always_comb begin
    first_n  = dec.lslot;
    second_n = dec.rslot;
    mode_n   = MD_PAR;
    unique case (dec.fmt)
      FMT_LONG: begin
        first_n  = dec.wide;
        second_n = '0;
        mode_n   = MD_SINGLE;
      end
      FMT_RL: begin                                   // R4
        first_n  = dec.rslot;
        second_n = dec.lslot;
        mode_n   = MD_SEQ;
      end
      FMT_LR: begin
        first_n  = dec.lslot;
        second_n = dec.rslot;
        mode_n   = MD_SEQ;
      end
      FMT_PAR: begin
        if (dec.lslot.test) begin                     // R6, R8
          first_n  = dec.lslot;
          second_n = dec.rslot;
          mode_n   = MD_COND;
        end else if (dec.rslot.test) begin            // R7
          first_n  = dec.rslot;
          second_n = dec.lslot;
          mode_n   = MD_COND;
        end else begin                                // R9
          first_n  = dec.lslot;
          second_n = dec.rslot;
          mode_n   = MD_PAR;
        end
      end
      default: ;
    endcase
    // only a gating slot carries the test flag
    first_n.test  = (mode_n == MD_COND);
    second_n.test = 1'b0;
  end

  always_comb begin
    unique case (mode_q)
      MD_SINGLE: go_second = 1'b0;
      MD_SEQ:    go_second = !(done_branch || done_exc);   // R5
      MD_COND:   go_second = done_cond;                     // R6
      MD_PAR:    go_second = !done_exc;                     // R9
      default:   go_second = 1'b0;
    endcase
  end

  // counter increments (R10, R5, R6)
  always_comb begin
    inc           = '0;
    inc[CI_CYC]   = accept;
    inc[CI_LONG]  = accept && (dec.fmt == FMT_LONG);
    inc[CI_PAR]   = accept && (dec.fmt == FMT_PAR);
    inc[CI_LR]    = accept && (dec.fmt == FMT_LR);
    inc[CI_RL]    = accept && (dec.fmt == FMT_RL);
    inc[CI_TRUE]  = done1 && (mode_q == MD_COND) && done_cond;
    inc[CI_FALSE] = done1 && (mode_q == MD_COND) && !done_cond;
    inc[CI_BSKIP] = done1 && (mode_q == MD_SEQ) && done_branch && !done_exc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      iss_valid <= 1'b0;
      iss_slot  <= '0;
      second_q  <= '0;
      mode_q    <= MD_SINGLE;
    end else begin
      iss_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (word_valid) begin
            state     <= ST_WAIT1;
            busy      <= 1'b1;
            iss_valid <= 1'b1;
            iss_slot  <= first_n;
            second_q  <= second_n;
            mode_q    <= mode_n;
          end
        end
        ST_WAIT1: begin
          if (done_valid) begin
            if (go_second) begin
              state     <= ST_WAIT2;
              iss_valid <= 1'b1;
              iss_slot  <= second_q;
            end else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end
          end
        end
        ST_WAIT2: begin
          if (done_valid) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_stat_counters.sv
module pkt_stat_counters
  import pkt_dispatch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CNT-1:0]            inc,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[i] <= '0;                   // R1
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;        // wraps
    end
  end

endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
  import pkt_dispatch_pkg::*;
#(
  parameter int              CNT_W     = 16,
  parameter logic [NGRP-1:0] TEST_MASK = 64'hF000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              iss_valid,
  output logic              iss_side,
  output logic              iss_long,
  output logic              iss_test,
  output logic [PAY_W-1:0]  iss_payload,
  output logic [GRP_W-1:0]  iss_group,
  input  logic              done_valid,
  input  logic              done_branch,
  input  logic              done_exc,
  input  logic              done_cond,
  output logic [CNT_W-1:0]  cnt_cycles,
  output logic [CNT_W-1:0]  cnt_long,
  output logic [CNT_W-1:0]  cnt_par,
  output logic [CNT_W-1:0]  cnt_lr,
  output logic [CNT_W-1:0]  cnt_rl,
  output logic [CNT_W-1:0]  cnt_true,
  output logic [CNT_W-1:0]  cnt_false,
  output logic [CNT_W-1:0]  cnt_bskip
);

  dec_t                          dec;
  slot_t                         slot;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  pkt_slot_decode #(.TEST_MASK(TEST_MASK)) u_dec (
    .word (word_data),
    .dec  (dec)
  );

  pkt_issue_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .word_valid  (word_valid),
    .dec         (dec),
    .done_valid  (done_valid),
    .done_branch (done_branch),
    .done_exc    (done_exc),
    .done_cond   (done_cond),
    .busy        (busy),
    .iss_valid   (iss_valid),
    .iss_slot    (slot),
    .inc         (inc)
  );

  pkt_stat_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (inc),
    .cnt (cnt)
  );

  assign iss_side    = slot.side;
  assign iss_long    = slot.lng;
  assign iss_test    = slot.test;
  assign iss_payload = slot.pay;
  assign iss_group   = slot.grp;

  assign cnt_cycles = cnt[CI_CYC];
  assign cnt_long   = cnt[CI_LONG];
  assign cnt_par    = cnt[CI_PAR];
  assign cnt_lr     = cnt[CI_LR];
  assign cnt_rl     = cnt[CI_RL];
  assign cnt_true   = cnt[CI_TRUE];
  assign cnt_false  = cnt[CI_FALSE];
  assign cnt_bskip  = cnt[CI_BSKIP];

endmodule

// File: rtl/pkt_dispatch_chk.sv
module pkt_dispatch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             word_valid,
  input logic             busy,
  input logic             iss_valid,
  input logic             iss_side,
  input logic             iss_long,
  input logic             done_valid,
  input logic [CNT_W-1:0] cnt_cycles
);

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !busy) |=> (busy && iss_valid)); // R11

  AST_ISSUE_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !done_valid) |=> !iss_valid); // R11

  AST_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> busy); // R11

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_valid) |=> busy); // R11

  AST_LONG_ON_LEFT: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_long) |-> !iss_side); // R2

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !word_valid && done_valid) |=> (!busy && !iss_valid)); // R12

  AST_CYCLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !busy) |=> (cnt_cycles == CNT_W'($past(cnt_cycles) + 1'b1))); // R10

endmodule

bind pkt_dispatch pkt_dispatch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .busy       (busy),
  .iss_valid  (iss_valid),
  .iss_side   (iss_side),
  .iss_long   (iss_long),
  .done_valid (done_valid),
  .cnt_cycles (cnt_cycles)
);

// File: tb/pkt_dispatch_tb_top.sv
module pkt_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          word_valid = 1'b0;
  logic [31:0]   word_data = '0;
  logic          busy, iss_valid, iss_side, iss_long, iss_test;
  logic [29:0]   iss_payload;
  logic [5:0]    iss_group;
  logic          done_valid = 1'b0, done_branch = 1'b0, done_exc = 1'b0, done_cond = 1'b0;
  logic [CW-1:0] cnt_cycles, cnt_long, cnt_par, cnt_lr, cnt_rl, cnt_true, cnt_false, cnt_bskip;

  pkt_dispatch #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .busy(busy), .iss_valid(iss_valid), .iss_side(iss_side), .iss_long(iss_long),
    .iss_test(iss_test), .iss_payload(iss_payload), .iss_group(iss_group),
    .done_valid(done_valid), .done_branch(done_branch), .done_exc(done_exc),
    .done_cond(done_cond), .cnt_cycles(cnt_cycles), .cnt_long(cnt_long),
    .cnt_par(cnt_par), .cnt_lr(cnt_lr), .cnt_rl(cnt_rl), .cnt_true(cnt_true),
    .cnt_false(cnt_false), .cnt_bskip(cnt_bskip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        side;
    logic        lng;
    logic        tst;
    logic [29:0] pay;
    logic [5:0]  grp;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    fails  = 0;
  int    exp_cnt[8];
  string cur_req = "R1";
  bit    reported = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  function automatic exp_t mk(input logic side, input logic lng, input logic tst,
                              input logic [29:0] pay, input logic [5:0] grp);
    exp_t e;
    e.side = side; e.lng = lng; e.tst = tst; e.pay = pay; e.grp = grp;
    return e;
  endfunction

  // short slot: zero-extended payload, group from slot bits 14:9 (R3)
  function automatic exp_t mks(input logic side, input logic tst, input logic [14:0] s);
    return mk(side, 1'b0, tst, {15'd0, s}, s[14:9]);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    exp_t got;
    if (!rst && iss_valid) begin
      got = mk(iss_side, iss_long, iss_test, iss_payload, iss_group);
      if (q.size() == 0) begin
        check(1'b0, cur_req, "unexpected issue", 64'(got), 64'h0);
      end else begin
        e = q.pop_front();
        check(got == e, cur_req, "issued slot", 64'(got), 64'(e));
      end
    end
  end

  task automatic check_counters(input string req);
    check(cnt_cycles == CW'(exp_cnt[0]), {req, "/R10"}, "cnt_cycles", cnt_cycles, exp_cnt[0]);
    check(cnt_long   == CW'(exp_cnt[1]), {req, "/R10"}, "cnt_long",   cnt_long,   exp_cnt[1]);
    check(cnt_par    == CW'(exp_cnt[2]), {req, "/R10"}, "cnt_par",    cnt_par,    exp_cnt[2]);
    check(cnt_lr     == CW'(exp_cnt[3]), {req, "/R10"}, "cnt_lr",     cnt_lr,     exp_cnt[3]);
    check(cnt_rl     == CW'(exp_cnt[4]), {req, "/R10"}, "cnt_rl",     cnt_rl,     exp_cnt[4]);
    check(cnt_true   == CW'(exp_cnt[5]), {req, "/R6"},  "cnt_true",   cnt_true,   exp_cnt[5]);
    check(cnt_false  == CW'(exp_cnt[6]), {req, "/R6"},  "cnt_false",  cnt_false,  exp_cnt[6]);
    check(cnt_bskip  == CW'(exp_cnt[7]), {req, "/R5"},  "cnt_bskip",  cnt_bskip,  exp_cnt[7]);
  endtask

  // driver: predicts the issue stream, drives the word and answers each issue
  task automatic run_word(input logic [31:0] w, input logic br, input logic ex,
                          input logic cd, input bit intrude, input string req);
    logic [14:0] ls, rs;
    bit lt, rt;
    int n;
    ls = w[29:15];
    rs = w[14:0];
    lt = (ls[14:9] >= 6'h3C);
    rt = (rs[14:9] >= 6'h3C);
    cur_req = req;
    n = 1;
    exp_cnt[0]++;
    case (w[31:30])
      2'b11: begin
        exp_cnt[1]++;
        q.push_back(mk(1'b0, 1'b1, 1'b0, w[29:0], w[29:24]));
      end
      2'b10: begin
        exp_cnt[4]++;
        q.push_back(mks(1'b1, 1'b0, rs));
        if (!br && !ex) begin q.push_back(mks(1'b0, 1'b0, ls)); n = 2; end
        else if (br && !ex) exp_cnt[7]++;
      end
      2'b01: begin
        exp_cnt[3]++;
        q.push_back(mks(1'b0, 1'b0, ls));
        if (!br && !ex) begin q.push_back(mks(1'b1, 1'b0, rs)); n = 2; end
        else if (br && !ex) exp_cnt[7]++;
      end
      default: begin
        exp_cnt[2]++;
        if (lt || rt) begin
          if (lt) q.push_back(mks(1'b0, 1'b1, ls));
          else    q.push_back(mks(1'b1, 1'b1, rs));
          if (cd) begin
            exp_cnt[5]++;
            n = 2;
            if (lt) q.push_back(mks(1'b1, 1'b0, rs));
            else    q.push_back(mks(1'b0, 1'b0, ls));
          end else begin
            exp_cnt[6]++;
          end
        end else begin
          q.push_back(mks(1'b0, 1'b0, ls));
          if (!ex) begin q.push_back(mks(1'b1, 1'b0, rs)); n = 2; end
        end
      end
    endcase

    while (busy) @(negedge clk);
    word_data  = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int wt;
      wt = 0;
      while (!iss_valid && wt < 8) begin @(negedge clk); wt++; end
      if (!iss_valid) begin
        check(1'b0, req, "missing issue", 64'(k), 64'(n));
        break;
      end
      if (intrude && k == 0) begin
        // R11: a word offered while busy must be ignored
        word_data  = ~w;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
      end
      done_valid  = 1'b1;
      done_branch = (k == 0) ? br : 1'b0;
      done_exc    = (k == 0) ? ex : 1'b0;
      done_cond   = (k == 0) ? cd : 1'b0;
      @(negedge clk);
      done_valid = 1'b0; done_branch = 1'b0; done_exc = 1'b0; done_cond = 1'b0;
    end
    check(busy == 1'b0, {req, "/R11"}, "busy after last completion", busy, 0);
    check(q.size() == 0, req, "slots not issued", q.size(), 0);
    check_counters(req);
  endtask

  // slot patterns
  localparam logic [14:0] PL_A = 15'h1234;  // group 0x09
  localparam logic [14:0] PL_B = 15'h0ABC;  // group 0x05
  localparam logic [14:0] TS_A = 15'h7E55;  // group 0x3F (test type)
  localparam logic [14:0] TS_B = 15'h7A0F;  // group 0x3D (test type)

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, cur_req, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0,      "R1", "busy",      busy, 0);
    check(iss_valid == 1'b0, "R1", "iss_valid", iss_valid, 0);
    check_counters("R1");

    // R2: long word
    run_word({2'b11, 30'h2ABC_1234}, 1'b1, 1'b1, 1'b0, 0, "R2");
    // R3/R4: left then right, a test-type group is not flagged here
    run_word({2'b01, PL_A, PL_B}, 1'b0, 1'b0, 1'b0, 0, "R3");
    run_word({2'b01, TS_A, PL_B}, 1'b0, 1'b0, 1'b1, 0, "R4");
    // R4: right then left
    run_word({2'b10, PL_A, PL_B}, 1'b0, 1'b0, 1'b0, 0, "R4");
    // R5: skips
    run_word({2'b01, PL_B, PL_A}, 1'b1, 1'b0, 1'b0, 0, "R5");
    run_word({2'b10, PL_A, PL_B}, 1'b0, 1'b1, 1'b0, 0, "R5");
    run_word({2'b01, PL_A, PL_B}, 1'b1, 1'b1, 1'b0, 0, "R5");
    run_word({2'b10, PL_B, PL_A}, 1'b1, 1'b0, 1'b1, 0, "R5");
    // R6: left test
    run_word({2'b00, TS_A, PL_B}, 1'b0, 1'b0, 1'b1, 0, "R6");
    run_word({2'b00, TS_B, PL_A}, 1'b0, 1'b1, 1'b0, 0, "R6");
    // R7: right test
    run_word({2'b00, PL_A, TS_B}, 1'b0, 1'b0, 1'b1, 0, "R7");
    run_word({2'b00, PL_B, TS_A}, 1'b1, 1'b0, 1'b0, 0, "R7");
    // R8: both test type
    run_word({2'b00, TS_B, TS_A}, 1'b0, 1'b0, 1'b1, 0, "R8");
    run_word({2'b00, TS_A, TS_B}, 1'b0, 1'b0, 1'b0, 0, "R8");
    // R9: plain parallel
    run_word({2'b00, PL_A, PL_B}, 1'b0, 1'b0, 1'b0, 0, "R9");
    run_word({2'b00, PL_B, PL_A}, 1'b0, 1'b1, 1'b0, 0, "R9");
    run_word({2'b00, PL_A, PL_B}, 1'b1, 1'b0, 1'b0, 0, "R9");
    // R11: word offered while busy is dropped
    run_word({2'b01, PL_A, PL_B}, 1'b0, 1'b0, 1'b0, 1, "R11");
    run_word({2'b11, 30'h0155_5AAA}, 1'b0, 1'b0, 1'b0, 1, "R11");

    // R12: completion while idle
    cur_req = "R12";
    @(negedge clk);
    done_valid = 1'b1; done_branch = 1'b1; done_exc = 1'b1; done_cond = 1'b1;
    @(negedge clk);
    done_valid = 1'b0; done_branch = 1'b0; done_exc = 1'b0; done_cond = 1'b0;
    check(iss_valid == 1'b0, "R12", "iss_valid after idle completion", iss_valid, 0);
    check(busy == 1'b0,      "R12", "busy after idle completion", busy, 0);
    @(negedge clk);
    check(iss_valid == 1'b0, "R12", "iss_valid one cycle later", iss_valid, 0);
    check_counters("R12");

    // R10: counters still track after the idle pulse
    run_word({2'b10, TS_B, PL_A}, 1'b0, 1'b0, 1'b0, 0, "R10");

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule